// File: doc/BRIEF.md
# Arithmetic Unit with Status Flag Register

This block performs five integer operations (add, subtract, bitwise AND, increment and decrement) on two operands at either full word width (16 bits) or byte width (the low 8 bits). The result is available combinationally in the same cycle as the operands. A set of status flags is derived from that result: carry/borrow, parity, nibble carry, zero, sign and signed overflow.

The flags live in a 16-bit register with a fixed bit layout. They are written on a clock edge when the flag-write enable is high. The same register also holds three control bits: direction, interrupt enable and trap. These are loaded from a separate 3-bit input under their own enable. An arithmetic flag write and a control-bit load may happen in the same cycle, and each touches only its own bits.

Top module: `arith_flag_unit`

## Requirements
- R1: After the active-low asynchronous reset, `flags_o` reads 0x0002.
- R2: `op_i` encodes ADD=0, SUB=1, AND=2, INC=3 (a+1), DEC=4 (a-1). `result_o` follows the operands in the same cycle, truncated to the selected width. With `word_i`=0 only the low 8 bits of the operands are used and `result_o[15:8]` is 0.
- R3: Carry (bit 0) is set on an unsigned carry out of ADD, or a borrow out of SUB, at the selected width. AND clears it. INC and DEC leave it unchanged.
- R4: Overflow (bit 11) reports signed overflow of ADD, SUB, INC and DEC at the selected width. AND clears it.
- R5: Zero (bit 6) is set when `result_o` is 0. Sign (bit 7) copies bit 15 of the result in word mode and bit 7 in byte mode.
- R6: Parity (bit 2) is set when the low 8 bits of the result hold an even number of ones, in either width.
- R7: Nibble carry (bit 4) equals a[4] xor b[4] xor result[4], where b is 1 for INC and DEC. This gives the carry or borrow between bits 3 and 4. AND clears it.
- R8: Flags change only on a clock edge with `flag_we_i`=1. Codes 5 to 7 are reserved: `result_o` equals `a_i` and the arithmetic flags are not written.
- R9: When `ctrl_we_i`=1, trap (bit 8), interrupt enable (bit 9) and direction (bit 10) load from `ctrl_i[0]`, `ctrl_i[1]` and `ctrl_i[2]`. An arithmetic write never changes them, and a control load never changes the arithmetic flags.
- R10: Bit 1 of `flags_o` always reads 1. Bits 3, 5 and 15:12 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation select |
| word_i | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand (unused by INC/DEC) |
| flag_we_i | input | 1 | Write arithmetic flags at the next edge |
| ctrl_we_i | input | 1 | Load control bits at the next edge |
| ctrl_i | input | 3 | {direction, interrupt enable, trap} |
| result_o | output | 16 | Operation result |
| flags_o | output | 16 | Flag register |

## Verification
An arithmetic flag write and a control-bit load can fall on the same clock edge, and both modify the single flag register. The bench provokes this by raising `flag_we_i` and `ctrl_we_i` together on an addition that sets carry, zero, parity and nibble carry, while loading direction and trap. It then judges the whole 16-bit word one cycle later. It follows with a write of each kind on its own and checks that neither disturbs the other's bits.

// File: rtl/afu_pkg.sv
package afu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_INC = 3'd3,
    OP_DEC = 3'd4
  } afu_op_e;

  localparam int unsigned FLAGS_W = 16;
  localparam int unsigned PAR_W   = 8;
  localparam int unsigned NIB_BIT = 4;

  localparam int unsigned CF_BIT = 0;
  localparam int unsigned PF_BIT = 2;
  localparam int unsigned AF_BIT = 4;
  localparam int unsigned ZF_BIT = 6;
  localparam int unsigned SF_BIT = 7;
  localparam int unsigned TF_BIT = 8;
  localparam int unsigned IF_BIT = 9;
  localparam int unsigned DF_BIT = 10;
  localparam int unsigned OF_BIT = 11;

  localparam logic [FLAGS_W-1:0] FLAGS_CONST = 16'h0002;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } arith_flags_t;

  typedef struct packed {
    logic df;
    logic ie;
    logic tf;
  } ctrl_flags_t;
endpackage

// File: rtl/afu_parity.sv
module afu_parity #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] data_i,
  output logic         even_o
);
  logic [W:0] acc;
  assign acc[0] = 1'b1;
  for (genvar i = 0; i < W; i++) begin : g_chain
    assign acc[i+1] = acc[i] ^ data_i[i];
  end
  assign even_o = acc[W];
endmodule

// File: rtl/afu_datapath.sv
module afu_datapath
  import afu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  afu_op_e             op_i,
  input  logic                word_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  output logic [DATA_W-1:0]   result_o,
  output arith_flags_t        flags_o,
  output logic                valid_o,
  output logic                keep_cf_o
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] a_m, b_src, b_m, res;
  logic [DATA_W:0]   sum, dif, raw;
  logic              is_add, is_sub, is_and;
  logic              a_s, b_s, r_s, co;
  logic              par_even;

  always_comb begin
    is_add = (op_i == OP_ADD) || (op_i == OP_INC);
    is_sub = (op_i == OP_SUB) || (op_i == OP_DEC);
    is_and = (op_i == OP_AND);
    b_src  = ((op_i == OP_INC) || (op_i == OP_DEC)) ? DATA_W'(1) : b_i;
    a_m    = word_i ? a_i   : {{HALF_W{1'b0}}, a_i[HALF_W-1:0]};
    b_m    = word_i ? b_src : {{HALF_W{1'b0}}, b_src[HALF_W-1:0]};
    sum    = {1'b0, a_m} + {1'b0, b_m};
    dif    = {1'b0, a_m} - {1'b0, b_m};
    if (is_add)      raw = sum;
    else if (is_sub) raw = dif;
    else             raw = {1'b0, a_m & b_m};
    // zero-extended operands: bit HALF_W is byte carry/borrow
    co  = word_i ? raw[DATA_W] : raw[HALF_W];
    res = word_i ? raw[DATA_W-1:0] : {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
    a_s = word_i ? a_m[DATA_W-1] : a_m[HALF_W-1];
    b_s = word_i ? b_m[DATA_W-1] : b_m[HALF_W-1];
    r_s = word_i ? res[DATA_W-1] : res[HALF_W-1];
  end

  afu_parity #(.W(PAR_W)) u_par (
    .data_i (res[PAR_W-1:0]),
    .even_o (par_even)
  );

  always_comb begin
    valid_o   = is_add || is_sub || is_and;
    keep_cf_o = (op_i == OP_INC) || (op_i == OP_DEC);
    result_o  = valid_o ? res : a_i;
    flags_o.cf = is_and ? 1'b0 : co;
    flags_o.pf = par_even;
    flags_o.af = is_and ? 1'b0 : (a_m[NIB_BIT] ^ b_m[NIB_BIT] ^ res[NIB_BIT]);
    flags_o.zf = (res == '0);
    flags_o.sf = r_s;
    if (is_add)      flags_o.of = (a_s == b_s) && (r_s != a_s);
    else if (is_sub) flags_o.of = (a_s != b_s) && (r_s != a_s);
    else             flags_o.of = 1'b0;
  end
endmodule

// File: rtl/afu_flag_reg.sv
module afu_flag_reg
  import afu_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               arith_we_i,
  input  logic               keep_cf_i,
  input  arith_flags_t       arith_i,
  input  logic               ctrl_we_i,
  input  ctrl_flags_t        ctrl_i,
  output logic [FLAGS_W-1:0] flags_o
);
  arith_flags_t ar_q;
  ctrl_flags_t  ct_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ar_q <= '0;
    end else if (arith_we_i) begin
      ar_q    <= arith_i;
      if (keep_cf_i) ar_q.cf <= ar_q.cf;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ct_q <= '0;
    else if (ctrl_we_i) ct_q <= ctrl_i;
  end

  always_comb begin
    flags_o         = FLAGS_CONST;
    flags_o[CF_BIT] = ar_q.cf;
    flags_o[PF_BIT] = ar_q.pf;
    flags_o[AF_BIT] = ar_q.af;
    flags_o[ZF_BIT] = ar_q.zf;
    flags_o[SF_BIT] = ar_q.sf;
    flags_o[OF_BIT] = ar_q.of;
    flags_o[TF_BIT] = ct_q.tf;
    flags_o[IF_BIT] = ct_q.ie;
    flags_o[DF_BIT] = ct_q.df;
  end
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import afu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         op_i,
  input  logic               word_i,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic               flag_we_i,
  input  logic               ctrl_we_i,
  input  logic [2:0]         ctrl_i,
  output logic [DATA_W-1:0]  result_o,
  output logic [FLAGS_W-1:0] flags_o
);
  afu_op_e      op;
  arith_flags_t new_flags;
  ctrl_flags_t  ctrl_in;
  logic         op_valid, keep_cf;

  assign op      = afu_op_e'(op_i);
  assign ctrl_in = ctrl_flags_t'(ctrl_i);

  afu_datapath #(.DATA_W(DATA_W)) u_dp (
    .op_i      (op),
    .word_i    (word_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .result_o  (result_o),
    .flags_o   (new_flags),
    .valid_o   (op_valid),
    .keep_cf_o (keep_cf)
  );

  afu_flag_reg u_freg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arith_we_i (flag_we_i && op_valid),
    .keep_cf_i  (keep_cf),
    .arith_i    (new_flags),
    .ctrl_we_i  (ctrl_we_i),
    .ctrl_i     (ctrl_in),
    .flags_o    (flags_o)
  );
endmodule

// File: rtl/afu_checker.sv
module afu_checker
  import afu_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [2:0]         op_i,
  input logic               word_i,
  input logic               flag_we_i,
  input logic               ctrl_we_i,
  input logic [15:0]        result_o,
  input logic [FLAGS_W-1:0] flags_o
);
  logic op_ok;
  assign op_ok = (op_i <= 3'd4);

  AST_CONST_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[1] && (flags_o[3] == 1'b0) && (flags_o[5] == 1'b0) && (flags_o[15:12] == 4'h0))); // R10

  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!word_i && op_ok) |-> (result_o[15:8] == 8'h00)); // R2

  AST_INCDEC_KEEP_CF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && ((op_i == 3'd3) || (op_i == 3'd4))) |=> (flags_o[CF_BIT] == $past(flags_o[CF_BIT]))); // R3

  AST_AND_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && (op_i == 3'd2)) |=> (!flags_o[CF_BIT] && !flags_o[OF_BIT] && !flags_o[AF_BIT])); // R4

  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && op_ok) |=> (flags_o[ZF_BIT] == ($past(result_o) == 16'h0000))); // R5

  AST_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_we_i && !ctrl_we_i) |=> $stable(flags_o)); // R8

  AST_RESERVED_NO_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_ok && !ctrl_we_i) |=> $stable(flags_o)); // R8

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i |=> $stable(flags_o[DF_BIT:TF_BIT])); // R9
endmodule

bind arith_flag_unit afu_checker u_chk (.*);

// File: tb/arith_flag_unit_bench.sv
module arith_flag_unit_bench;
  typedef struct packed {
    logic [2:0]  op;
    logic        word;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] res;
    logic [15:0] flg;
  } vec_t;

  // op: ADD=0 SUB=1 AND=2 INC=3 DEC=4; flags CF0 PF2 AF4 ZF6 SF7 OF11, bit1 const
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b1, 16'h7FFF, 16'h0001, 16'h8000, 16'h0896}, // add word signed overflow
    '{3'd0, 1'b1, 16'hFFFF, 16'h0001, 16'h0000, 16'h0057}, // add word carry, zero
    '{3'd3, 1'b1, 16'h7FFF, 16'h0000, 16'h8000, 16'h0897}, // inc keeps CF=1
    '{3'd1, 1'b1, 16'h0000, 16'h0001, 16'hFFFF, 16'h0097}, // sub borrow
    '{3'd1, 1'b1, 16'h8000, 16'h0001, 16'h7FFF, 16'h0816}, // sub signed overflow
    '{3'd2, 1'b1, 16'hF0F0, 16'h0FF0, 16'h00F0, 16'h0006}, // and clears CF/OF/AF
    '{3'd4, 1'b1, 16'h0000, 16'h0000, 16'hFFFF, 16'h0096}, // dec keeps CF=0
    '{3'd0, 1'b0, 16'h12FF, 16'h3401, 16'h0000, 16'h0057}, // byte add carry at bit 7
    '{3'd4, 1'b0, 16'hAB80, 16'h0000, 16'h007F, 16'h0813}, // byte dec overflow, odd parity
    '{3'd1, 1'b0, 16'h0050, 16'h0070, 16'h00E0, 16'h0083}, // byte sub borrow
    '{3'd2, 1'b0, 16'hFF81, 16'hFF80, 16'h0080, 16'h0082}, // byte and sign
    '{3'd0, 1'b1, 16'h0100, 16'h0000, 16'h0100, 16'h0006}, // parity low byte only
    '{3'd0, 1'b0, 16'h0008, 16'h0008, 16'h0010, 16'h0012}  // nibble carry
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = '0;
  logic        word = 1'b1;
  logic [15:0] a = '0, b = '0;
  logic        flag_we = 1'b0, ctrl_we = 1'b0;
  logic [2:0]  ctrl = '0;
  logic [15:0] result, flags;
  int          n_chk = 0, n_fail = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  arith_flag_unit u_arith_flag_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .word_i(word), .a_i(a), .b_i(b),
    .flag_we_i(flag_we), .ctrl_we_i(ctrl_we), .ctrl_i(ctrl),
    .result_o(result), .flags_o(flags)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] o, input logic w, input logic [15:0] x,
                       input logic [15:0] y, input logic fwe, input logic cwe,
                       input logic [2:0] c);
    op = o; word = w; a = x; b = y; flag_we = fwe; ctrl_we = cwe; ctrl = c;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset flags", flags, 16'h0002);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flags after release", flags, 16'h0002);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].op, VECS[i].word, VECS[i].a, VECS[i].b, 1'b1, 1'b0, 3'b000);
      #1;
      check($sformatf("R2 result vec %0d", i), result, VECS[i].res);
      @(negedge clk);
      check($sformatf("R3 R4 R5 R6 R7 flags vec %0d", i), flags, VECS[i].flg);
    end

    // R8: no write enable -> flags hold
    drive(3'd0, 1'b1, 16'hFFFF, 16'h0001, 1'b0, 1'b0, 3'b000);
    @(negedge clk);
    check("R8 hold without flag_we", flags, 16'h0012);

    // R8: reserved opcode passes a, no flag write
    drive(3'd6, 1'b1, 16'hBEEF, 16'h1234, 1'b1, 1'b0, 3'b000);
    #1;
    check("R8 reserved result", result, 16'hBEEF);
    @(negedge clk);
    check("R8 reserved flags unchanged", flags, 16'h0012);

    // R9: arithmetic write and control load on the same edge
    drive(3'd0, 1'b1, 16'hFFFF, 16'h0001, 1'b1, 1'b1, 3'b101);
    @(negedge clk);
    check("R9 simultaneous write", flags, 16'h0557);

    drive(3'd2, 1'b1, 16'h0000, 16'h0000, 1'b1, 1'b0, 3'b000);
    @(negedge clk);
    check("R9 arith write keeps ctrl", flags, 16'h0546);

    drive(3'd0, 1'b1, 16'h7FFF, 16'h0001, 1'b0, 1'b1, 3'b010);
    @(negedge clk);
    check("R9 ctrl load keeps arith", flags, 16'h0246);
    check("R10 constant bits", flags & 16'hF02A, 16'h0002);

    // R1: asynchronous reset mid-run
    drive(3'd0, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b0, 3'b000);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", flags, 16'h0002);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule